// File: doc/BRIEF.md
# NAND Page Read Command Sequencer

This block opens a page read on a raw NAND device and pulls the page into a local buffer, one chunk at a time. A single-cycle `start` with a page number launches a fixed chain of latch operations: a read command, column address bytes, the row address bytes, a trailing address byte, an optional confirm command for large pages, and then one output request per 512-byte chunk of the page. Each operation appears on a small operation interface (`opValid`, `opType`, `opByte`, `opBufIdx`). The device side acknowledges it with a single-cycle `opDone`.

The page size and the device's total page count are elaboration parameters. The number of row address bytes is derived from them when the block is built. The electrical bus timing, the data path and error correction live elsewhere. When the last chunk has been acknowledged, the block pulses `done` and returns to idle.

Top module: `nand_read_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done` and `opValid` are all low.
- R2: Every sequence begins with a command operation carrying byte 0x00. When PAGE_BYTES exceeds 512, a command operation carrying 0x30 follows the last address operation and comes before the first output operation. The `opType` encoding is 0 for command, 1 for address and 2 for output.
- R3: The command is followed by one address operation with byte 0x00. A second 0x00 address operation follows only when PAGE_BYTES exceeds 512.
- R4: Row address operations then carry pageNum[7:0], pageNum[15:8] and so on, lowest byte first. Their number is the count of 8-bit right shifts of (DEV_PAGES-1) needed to reach zero, with a minimum of one.
- R5: When pageNum is greater than DEV_PAGES, no row address operations are issued at all.
- R6: One address operation carrying 0x00 always follows the row address portion.
- R7: While `opValid` is high and `opDone` is low, `opType`, `opByte` and `opBufIdx` hold steady. After the cycle in which `opDone` is seen, `opValid` is low for exactly one cycle before the next operation is presented.
- R8: The sequence ends with PAGE_BYTES/512 output operations, each with `opByte` 0x00 and with `opBufIdx` counting up 0, 1, 2 and so on. Every other operation carries `opBufIdx` 0.
- R9: `done` is a one-cycle pulse in the cycle after the last output operation's `opDone`. `busy` is already low in that cycle.
- R10: A `start` that arrives while `busy` is high is ignored. The running sequence continues with its original page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a page read, accepted only when idle |
| pageNum | input | PAGE_NUM_W | Page number sampled with an accepted start |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when the sequence has finished |
| opValid | output | 1 | An operation is presented to the device side |
| opType | output | 2 | Operation kind: 0 command, 1 address, 2 output |
| opByte | output | 8 | Command or address byte (0x00 for output) |
| opBufIdx | output | CHUNK_W | Local buffer chunk index for output operations |
| opDone | input | 1 | Single-cycle completion from the device side |

## Verification
A wrong step or a wrong counter in this block shows up at the ports as a misplaced, missing or extra operation. The bench compares the entire operation log of each sequence against a list it computes arithmetically, so a fault shows in the first operation after it takes effect. A wrong row-enable decision or a wrong shifter value changes an address byte or the operation count within a few handshakes of start. A handshake fault, such as fields changing while an operation waits or a missing clear cycle, is caught by a device model within one clock. The bench sweeps every page number around the boundaries of a small 512-byte configuration, and it covers the corner pages of a 2048-byte configuration with three row bytes.

// File: rtl/nand_rdseq_pkg.sv
package nand_rdseq_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_OUT  = 2'd2
  } opKind_e;

  typedef struct packed {
    logic loadPage;
    logic rowAdv;
    logic chunkAdv;
    logic selRow;
    logic selConfirm;
  } dpStrobe_t;

  localparam logic [7:0] BYTE_READ    = 8'h00;
  localparam logic [7:0] BYTE_CONFIRM = 8'h30;
  localparam int         CHUNK_BYTES  = 512;

  function automatic int rowBytesFor(input longint devPages);
    longint rem;
    int n;
    n   = 1;
    rem = (devPages - 1) >> 8;
    while (rem != 0) begin
      n++;
      rem = rem >> 8;
    end
    return n;
  endfunction

  function automatic int widthFor(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/nand_rdseq_dp.sv
module nand_rdseq_dp
  import nand_rdseq_pkg::*;
#(
  parameter int PAGE_NUM_W = 24,
  parameter int DEV_PAGES  = 131072,
  parameter int ROW_BYTES  = 3,
  parameter int CHUNKS     = 4,
  parameter int CHUNK_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PAGE_NUM_W-1:0] pageNum,
  input  dpStrobe_t             strb,
  output logic [7:0]            opByte,
  output logic [CHUNK_W-1:0]    bufIdx,
  output logic                  rowsOk,
  output logic                  lastRow,
  output logic                  lastChunk
);

  localparam int SH_W      = (PAGE_NUM_W > 8) ? PAGE_NUM_W : 8;
  localparam int ROW_CNT_W = widthFor(ROW_BYTES);

  logic [SH_W-1:0]      pageSh;
  logic [ROW_CNT_W-1:0] rowCnt;
  logic [CHUNK_W-1:0]   chunkCnt;

  assign lastRow   = (rowCnt == ROW_CNT_W'(ROW_BYTES - 1));
  assign lastChunk = (chunkCnt == CHUNK_W'(CHUNKS - 1));
  assign bufIdx    = chunkCnt;

  always_comb begin
    if (strb.selConfirm)  opByte = BYTE_CONFIRM;
    else if (strb.selRow) opByte = pageSh[7:0];
    else                  opByte = 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageSh   <= '0;
      rowsOk   <= 1'b0;
      rowCnt   <= '0;
      chunkCnt <= '0;
    end else if (strb.loadPage) begin
      pageSh   <= SH_W'(pageNum);
      rowsOk   <= (64'(pageNum) <= 64'(DEV_PAGES));
      rowCnt   <= '0;
      chunkCnt <= '0;
    end else begin
      if (strb.rowAdv && !lastRow) begin
        pageSh <= pageSh >> 8;
        rowCnt <= rowCnt + 1'b1;
      end
      if (strb.chunkAdv && !lastChunk)
        chunkCnt <= chunkCnt + 1'b1;
    end
  end

  assert_row_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    32'(rowCnt) < ROW_BYTES);

  assert_chunk_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    32'(chunkCnt) < CHUNKS);

  assert_rows_decision_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadPage |=> $stable(rowsOk));

endmodule

// File: rtl/nand_rdseq_ctrl.sv
module nand_rdseq_ctrl
  import nand_rdseq_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      opDone,
  input  logic      rowsOk,
  input  logic      lastRow,
  input  logic      lastChunk,
  output logic      busy,
  output logic      done,
  output logic      opValid,
  output opKind_e   opKind,
  output dpStrobe_t strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDCMD, ST_COL0, ST_COL1, ST_ROW, ST_TAIL, ST_CONF, ST_OUT
  } step_e;

  step_e step, nextStep;
  logic  gap;
  logic  advance;

  assign busy    = (step != ST_IDLE);
  assign opValid = busy && !gap;
  assign advance = opValid && opDone;

  always_comb begin
    case (step)
      ST_RDCMD: nextStep = ST_COL0;
      ST_COL0:  nextStep = LARGE_PAGE ? ST_COL1 : (rowsOk ? ST_ROW : ST_TAIL);
      ST_COL1:  nextStep = rowsOk ? ST_ROW : ST_TAIL;
      ST_ROW:   nextStep = lastRow ? ST_TAIL : ST_ROW;
      ST_TAIL:  nextStep = LARGE_PAGE ? ST_CONF : ST_OUT;
      ST_CONF:  nextStep = ST_OUT;
      ST_OUT:   nextStep = lastChunk ? ST_IDLE : ST_OUT;
      default:  nextStep = ST_IDLE;
    endcase
  end

  always_comb begin
    case (step)
      ST_RDCMD, ST_CONF: opKind = OP_CMD;
      ST_OUT:            opKind = OP_OUT;
      default:           opKind = OP_ADDR;
    endcase
  end

  always_comb begin
    strb.loadPage   = start && !busy;
    strb.rowAdv     = advance && (step == ST_ROW);
    strb.chunkAdv   = advance && (step == ST_OUT);
    strb.selRow     = (step == ST_ROW);
    strb.selConfirm = (step == ST_CONF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step <= ST_IDLE;
      gap  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.loadPage) begin
        step <= ST_RDCMD;
        gap  <= 1'b0;
      end else if (advance) begin
        step <= nextStep;
        gap  <= (nextStep != ST_IDLE);
        done <= (nextStep == ST_IDLE);
      end else if (gap) begin
        gap <= 1'b0;
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !opValid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opDone) |=> (opValid && $stable(step)));

  assert_clear_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opDone) |=> !opValid);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !opDone) |=> (busy && $stable(step)));

endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq
  import nand_rdseq_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int DEV_PAGES  = 131072,
  parameter int PAGE_NUM_W = 24,
  localparam int CHUNKS    = (PAGE_BYTES / CHUNK_BYTES > 0) ? PAGE_BYTES / CHUNK_BYTES : 1,
  localparam int CHUNK_W   = widthFor(CHUNKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [PAGE_NUM_W-1:0] pageNum,
  output logic                  busy,
  output logic                  done,
  output logic                  opValid,
  output logic [1:0]            opType,
  output logic [7:0]            opByte,
  output logic [CHUNK_W-1:0]    opBufIdx,
  input  logic                  opDone
);

  localparam int ROW_BYTES  = rowBytesFor(longint'(DEV_PAGES));
  localparam bit LARGE_PAGE = (PAGE_BYTES > CHUNK_BYTES);

  dpStrobe_t strb;
  opKind_e   opKind;
  logic      rowsOk, lastRow, lastChunk;

  nand_rdseq_ctrl #(
    .LARGE_PAGE(LARGE_PAGE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opDone   (opDone),
    .rowsOk   (rowsOk),
    .lastRow  (lastRow),
    .lastChunk(lastChunk),
    .busy     (busy),
    .done     (done),
    .opValid  (opValid),
    .opKind   (opKind),
    .strb     (strb)
  );

  nand_rdseq_dp #(
    .PAGE_NUM_W(PAGE_NUM_W),
    .DEV_PAGES (DEV_PAGES),
    .ROW_BYTES (ROW_BYTES),
    .CHUNKS    (CHUNKS),
    .CHUNK_W   (CHUNK_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pageNum  (pageNum),
    .strb     (strb),
    .opByte   (opByte),
    .bufIdx   (opBufIdx),
    .rowsOk   (rowsOk),
    .lastRow  (lastRow),
    .lastChunk(lastChunk)
  );

  assign opType = opKind;

endmodule

// File: tb/nand_read_seq_tb.sv
module nand_read_seq_devmodel #(
  parameter int IDX_W = 1,
  parameter int SEED  = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             opValid,
  input  logic [1:0]       opType,
  input  logic [7:0]       opByte,
  input  logic [IDX_W-1:0] opBufIdx,
  output logic             opDone
);
  logic [17:0] logMem [64];
  int          logCount;
  int          protoErr;
  int          waitCnt;
  logic        chkGap;
  logic [17:0] held;
  logic [17:0] cur;

  assign cur = {opType, opByte, 8'(opBufIdx)};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opDone <= 1'b0; logCount <= 0; protoErr <= 0; waitCnt <= 0;
      chkGap <= 1'b0; held <= '0;
    end else if (clear) begin
      logCount <= 0; protoErr <= 0; waitCnt <= 0; chkGap <= 1'b0; opDone <= 1'b0;
    end else if (opDone) begin
      opDone <= 1'b0;
      chkGap <= 1'b1;
    end else if (chkGap) begin
      chkGap <= 1'b0;
      if (opValid) protoErr <= protoErr + 1;
    end else if (opValid) begin
      if (waitCnt == 0) held <= cur;
      else if (cur != held) protoErr <= protoErr + 1;
      if (waitCnt >= (logCount + SEED) % 3) begin
        if (logCount < 64) logMem[logCount] <= cur;
        logCount <= logCount + 1;
        opDone   <= 1'b1;
        waitCnt  <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end
endmodule

module nand_read_seq_tb;
  localparam int BIG_PB  = 2048;
  localparam int BIG_DP  = 131072;
  localparam int SML_PB  = 512;
  localparam int SML_DP  = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearLog = 1'b0;
  always #2 clk = ~clk;

  logic        startBig = 1'b0, startSml = 1'b0;
  logic [23:0] pageBig = '0, pageSml = '0;
  logic        busyBig, doneBig, opValidBig, opDoneBig;
  logic        busySml, doneSml, opValidSml, opDoneSml;
  logic [1:0]  opTypeBig, opTypeSml;
  logic [7:0]  opByteBig, opByteSml;
  logic [1:0]  opBufIdxBig;
  logic [0:0]  opBufIdxSml;

  nand_read_seq #(.PAGE_BYTES(BIG_PB), .DEV_PAGES(BIG_DP), .PAGE_NUM_W(24)) u_dut (
    .clk(clk), .rstN(rstN), .start(startBig), .pageNum(pageBig),
    .busy(busyBig), .done(doneBig), .opValid(opValidBig), .opType(opTypeBig),
    .opByte(opByteBig), .opBufIdx(opBufIdxBig), .opDone(opDoneBig));

  nand_read_seq #(.PAGE_BYTES(SML_PB), .DEV_PAGES(SML_DP), .PAGE_NUM_W(24)) u_dutSmall (
    .clk(clk), .rstN(rstN), .start(startSml), .pageNum(pageSml),
    .busy(busySml), .done(doneSml), .opValid(opValidSml), .opType(opTypeSml),
    .opByte(opByteSml), .opBufIdx(opBufIdxSml), .opDone(opDoneSml));

  nand_read_seq_devmodel #(.IDX_W(2), .SEED(1)) u_modelBig (
    .clk(clk), .rstN(rstN), .clear(clearLog), .opValid(opValidBig), .opType(opTypeBig),
    .opByte(opByteBig), .opBufIdx(opBufIdxBig), .opDone(opDoneBig));

  nand_read_seq_devmodel #(.IDX_W(1), .SEED(2)) u_modelSmall (
    .clk(clk), .rstN(rstN), .clear(clearLog), .opValid(opValidSml), .opType(opTypeSml),
    .opByte(opByteSml), .opBufIdx(opBufIdxSml), .opDone(opDoneSml));

  int nTests = 0;
  int nFail  = 0;

  logic [17:0] expMem [64];
  string       expTag [64];
  int          expCount;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] t, input logic [7:0] b, input int idx, input string tag);
    if (expCount < 64) begin
      expMem[expCount] = {t, b, 8'(idx)};
      expTag[expCount] = tag;
    end
    expCount++;
  endtask

  task automatic buildExp(input int pageBytes, input longint devPages, input longint page);
    int rows;
    longint rem;
    expCount = 0;
    push(2'd0, 8'h00, 0, "R2");
    push(2'd1, 8'h00, 0, "R3");
    if (pageBytes > 512) push(2'd1, 8'h00, 0, "R3");
    if (page <= devPages) begin
      rows = 1;
      rem  = (devPages - 1) / 256;
      while (rem != 0) begin rows++; rem = rem / 256; end
      for (int k = 0; k < rows; k++)
        push(2'd1, 8'((page / (longint'(1) << (8 * k))) % 256), 0, "R4");
    end
    push(2'd1, 8'h00, 0, "R6");
    if (pageBytes > 512) push(2'd0, 8'h30, 0, "R2");
    for (int c = 0; c < pageBytes / 512; c++) push(2'd2, 8'h00, c, "R8");
  endtask

  task automatic runSeq(input bit big, input longint page, input bit inject);
    bit seen;
    int gotCount, gotErr;
    logic [17:0] got;
    buildExp(big ? BIG_PB : SML_PB, big ? BIG_DP : SML_DP, page);
    @(negedge clk); clearLog = 1'b1;
    @(negedge clk); clearLog = 1'b0;
    if (big) begin startBig = 1'b1; pageBig = 24'(page); end
    else     begin startSml = 1'b1; pageSml = 24'(page); end
    @(negedge clk);
    startBig = 1'b0; startSml = 1'b0;
    seen = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (big ? doneBig : doneSml) begin seen = 1'b1; break; end
      @(negedge clk);
      if (inject && cyc == 4) begin
        if (big) begin startBig = 1'b1; pageBig = 24'h00FF00; end
        else     begin startSml = 1'b1; pageSml = 24'h000011; end
      end else begin
        startBig = 1'b0; startSml = 1'b0;
      end
    end
    chk(seen, "R9", "done seen", seen, 1);
    if (seen) begin
      chk(!(big ? busyBig : busySml), "R9", "busy low with done", big ? busyBig : busySml, 0);
      @(negedge clk);
      chk(!(big ? doneBig : doneSml), "R9", "done one cycle", big ? doneBig : doneSml, 0);
      chk(!(big ? opValidBig : opValidSml), "R1", "idle opValid", big ? opValidBig : opValidSml, 0);
    end
    gotCount = big ? u_modelBig.logCount : u_modelSmall.logCount;
    gotErr   = big ? u_modelBig.protoErr : u_modelSmall.protoErr;
    chk(gotCount == expCount,
        (page > (big ? BIG_DP : SML_DP)) ? "R5" : (inject ? "R10" : "R4"),
        "operation count", gotCount, expCount);
    chk(gotErr == 0, "R7", "handshake violations", gotErr, 0);
    for (int i = 0; i < expCount && i < 64 && i < gotCount; i++) begin
      got = big ? u_modelBig.logMem[i] : u_modelSmall.logMem[i];
      chk(got == expMem[i], inject ? "R10" : expTag[i], $sformatf("op %0d page %0h", i, page),
          got, expMem[i]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busyBig && !doneBig && !opValidBig, "R1", "reset state big",
        {busyBig, doneBig, opValidBig}, 0);
    chk(!busySml && !doneSml && !opValidSml, "R1", "reset state small",
        {busySml, doneSml, opValidSml}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // large page, three row bytes: corners and spread
    runSeq(1'b1, 0, 1'b0);
    runSeq(1'b1, 1, 1'b0);
    runSeq(1'b1, 255, 1'b0);
    runSeq(1'b1, 256, 1'b0);
    runSeq(1'b1, 65536, 1'b0);
    runSeq(1'b1, 'h12345, 1'b0);
    runSeq(1'b1, BIG_DP - 1, 1'b0);
    runSeq(1'b1, BIG_DP, 1'b0);
    runSeq(1'b1, BIG_DP + 1, 1'b0);
    runSeq(1'b1, 'hFFFFFF, 1'b0);
    for (int j = 1; j < 8; j++) runSeq(1'b1, (j * 7919 * 13) % (BIG_DP + 4), 1'b0);

    // R10: start during a running sequence
    runSeq(1'b1, 'h1ABCD, 1'b1);
    runSeq(1'b0, 'h42, 1'b1);

    // small page, one row byte: sweep every page around the limit
    for (int p = 0; p <= 300; p++) runSeq(1'b0, p, 1'b0);

    // R1: reset in the middle of a sequence
    @(negedge clk); startBig = 1'b1; pageBig = 24'h000777;
    @(negedge clk); startBig = 1'b0;
    repeat (10) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(!busyBig && !opValidBig && !doneBig, "R1", "mid-run reset",
        {busyBig, opValidBig, doneBig}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runSeq(1'b1, 'h000777, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule